// File: doc/BRIEF.md
# Opcode Fetch and Refresh Bus Sequencer

This block drives the external memory bus of an 8-bit processor core. The core hands it one request at a time: a cycle kind, a 16-bit address and, for stores, a data byte. The sequencer steps through the clock states of that bus cycle. It drives the address and the active-low strobes, adds wait states on demand from slow memory, and returns the byte it read. Each bus state (T-state) lasts two clocks. The first clock is the high half of the state and the second clock is the low half, so strobe edges that fall mid-state land on a clock boundary.

An opcode fetch takes four states. The first two read the opcode. The last two reuse the bus for a dynamic-memory refresh: the core's interrupt-page byte goes on the upper address half and its refresh counter on the lower half, the refresh strobe goes low, and the memory-request strobe pulses a second time. In the closing clock of every fetch the block offers the next refresh-counter value, with the top bit kept and the lower seven bits stepped. Memory reads and writes take three states. A done pulse in the final clock of each cycle lets the core present its next request in that same clock, so cycles can run back-to-back.

Top module: `fetch_bus_seq`

## Requirements
- R1: A fetch holds `m1N` low for all of T1, T2 and any wait states. `mreqN` and `rdN` go low from the second clock of T1 through the end of T2 and any wait states. Over these states `addr` equals the request address.
- R2: `waitN` is sampled at the end of the first clock of T2 and of each wait state. Each low sample adds one wait state of two clocks, with strobes held as in T2.
- R3: The fetched opcode is captured on the clock edge that starts T3. It appears on `rdData` and is valid in the done clock. `m1N` and `rdN` are high during T3.
- R4: During T3 and T4 of a fetch, `addr` is `{iReg, rReg}`, `rfshN` is low for all four clocks, and `rdN` and `m1N` stay high. `mreqN` is low in the second clock of T3 and the first clock of T4, so a fetch has exactly two falling edges of `mreqN`.
- R5: `rStep` is high only in the final clock of a fetch. In that clock `rNext` carries `rReg` bit 7 unchanged and `rReg[6:0]+1` modulo 128 below it.
- R6: A read (`reqKind`=1) takes T1 to T3 plus waits. `mreqN` and `rdN` are low from the second clock of T1 through the first clock of T3. Data is captured at the end of that first T3 clock, and `m1N` and `rfshN` stay high.
- R7: A write (`reqKind`=2) drives `dataOut` with `dataOe` high from the start of T1 to the end of T3. `mreqN` is low from the second clock of T1 through the first clock of T3. `wrN` is low from the second clock of T2 through the first clock of T3. `wrN` and `rdN` are never low together.
- R8: While `rstN` is low, all strobes are high and `dataOe` and `cycDone` are low. After release, two dummy states (four clocks) pass before the first T1 begins, even with a request waiting.
- R9: `cycDone` is a one-clock pulse in the final clock of each cycle. A request valid in that clock begins T1 on the next clock (`reqKind` 0 = fetch, 1 = read, 2 = write, 3 acts as fetch). A fetch then spans 8 clocks and a read or write 6, plus 2 per wait state.
- R10: With no request pending, all strobes stay high, `dataOe` is low and `cycDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per bus state |
| rstN | input | 1 | Asynchronous active-low reset |
| waitN | input | 1 | Active-low wait request from memory |
| reqValid | input | 1 | Core has a cycle request |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write |
| reqAddr | input | 16 | Cycle address |
| reqWdata | input | 8 | Byte to store on a write |
| iReg | input | 8 | Interrupt-page byte for refresh address |
| rReg | input | 8 | Refresh counter for refresh address |
| dataIn | input | 8 | Data bus input |
| addr | output | 16 | Address bus |
| dataOut | output | 8 | Data bus output |
| dataOe | output | 1 | Data bus output enable |
| m1N | output | 1 | Opcode-fetch marker, active low |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| rfshN | output | 1 | Refresh strobe, active low |
| rdData | output | 8 | Captured read or opcode byte |
| cycDone | output | 1 | Final clock of a cycle |
| rStep | output | 1 | Refresh counter update strobe |
| rNext | output | 8 | Next refresh counter value |

## Verification
Three events share the closing clock of a fetch: the refresh address is still on the bus, `rStep` publishes the next counter, and the core swaps in its next request. The bench provokes this by issuing every following request, and the new refresh counter, inside that done clock. It then judges three things: the refresh address seen before the swap matches the old counter, the next T1 begins exactly one clock later, and each cycle's clock count matches. Wait states are injected by a memory model that counts memory-request clocks, so the wait samples also land on the states that the bench expects.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2
  } cyc_kind_e;

  typedef enum logic [2:0] {
    ST_DUMMY0,
    ST_DUMMY1,
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_T4
  } bus_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic refreshAddr;
    logic driveData;
  } dp_ctl_t;

endpackage

// File: rtl/fbs_ctrl.sv
module fbs_ctrl
  import fbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       waitN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output dp_ctl_t    ctl,
  output logic       m1N,
  output logic       mreqN,
  output logic       rdN,
  output logic       wrN,
  output logic       rfshN,
  output logic       cycDone,
  output logic       rStep
);

  bus_state_e state, stateNext, startSel;
  cyc_kind_e  kindQ, kindReq;
  logic       phase;      // 0: first clock of a T-state, 1: second clock
  logic       waitSeen;

  always_comb begin
    if (reqKind == 2'd2)      kindReq = KIND_WRITE;
    else if (reqKind == 2'd1) kindReq = KIND_READ;
    else                      kindReq = KIND_FETCH;
  end

  always_comb startSel = reqValid ? ST_T1 : ST_IDLE;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_DUMMY0:          stateNext = ST_DUMMY1;
      ST_DUMMY1, ST_IDLE: stateNext = startSel;
      ST_T1:              stateNext = ST_T2;
      ST_T2, ST_TW:       stateNext = waitSeen ? ST_TW : ST_T3;
      ST_T3:              stateNext = (kindQ == KIND_FETCH) ? ST_T4 : startSel;
      ST_T4:              stateNext = startSel;
      default:            stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_DUMMY0;
      phase    <= 1'b0;
      kindQ    <= KIND_FETCH;
      waitSeen <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) state <= stateNext;
      if (phase && stateNext == ST_T1) kindQ <= kindReq;
      if (!phase && (state == ST_T2 || state == ST_TW)) waitSeen <= ~waitN;
    end
  end

  logic isFetch, isRead, isWrite, early, t1Late, t3Early;
  assign isFetch = (kindQ == KIND_FETCH);
  assign isRead  = (kindQ == KIND_READ);
  assign isWrite = (kindQ == KIND_WRITE);
  // second clock of T1 through the last wait state
  assign early   = (state == ST_T1 && phase) || state == ST_T2 || state == ST_TW;
  assign t1Late  = (state == ST_T2 && phase) || state == ST_TW;
  assign t3Early = (state == ST_T3) && !phase;

  always_comb begin
    m1N   = !(isFetch && (state == ST_T1 || state == ST_T2 || state == ST_TW));
    rdN   = !((!isWrite && early) || (isRead && t3Early));
    wrN   = !(isWrite && (t1Late || t3Early));
    mreqN = !(early || (!isFetch && t3Early) ||
              (isFetch && ((state == ST_T3 && phase) || (state == ST_T4 && !phase))));
    rfshN = !(isFetch && (state == ST_T3 || state == ST_T4));
  end

  always_comb begin
    cycDone = phase && ((state == ST_T4) || (state == ST_T3 && !isFetch));
    rStep   = phase && (state == ST_T4);
    ctl.latchReq    = phase && (stateNext == ST_T1);
    ctl.capture     = (isFetch && phase && (state == ST_T2 || state == ST_TW) && !waitSeen) ||
                      (isRead && t3Early);
    ctl.refreshAddr = isFetch && (state == ST_T3 || state == ST_T4);
    ctl.driveData   = isWrite && (state == ST_T1 || state == ST_T2 ||
                                  state == ST_TW || state == ST_T3);
  end

endmodule

// File: rtl/fbs_dpath.sv
module fbs_dpath
  import fbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RCNT_W = 7,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] iReg,
  input  logic [DATA_W-1:0] rReg,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rNext
);

  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] wdHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      wdHold   <= '0;
      rdData   <= '0;
    end else begin
      if (ctl.latchReq) begin
        addrHold <= reqAddr;
        wdHold   <= reqWdata;
      end
      if (ctl.capture) rdData <= dataIn;
    end
  end

  assign addr    = ctl.refreshAddr ? {iReg, rReg} : addrHold;
  assign dataOut = wdHold;
  assign dataOe  = ctl.driveData;

  generate
    if (RCNT_W >= DATA_W) begin : g_fullStep
      assign rNext = rReg + DATA_W'(1);
    end else begin : g_lowStep
      assign rNext = {rReg[DATA_W-1:RCNT_W], rReg[RCNT_W-1:0] + RCNT_W'(1)};
    end
  endgenerate

endmodule

// File: rtl/fetch_bus_seq.sv
module fetch_bus_seq
  import fbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RCNT_W = 7,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] iReg,
  input  logic [DATA_W-1:0] rReg,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              m1N,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic              rfshN,
  output logic [DATA_W-1:0] rdData,
  output logic              cycDone,
  output logic              rStep,
  output logic [DATA_W-1:0] rNext
);

  dp_ctl_t ctl;

  fbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .waitN(waitN), .reqValid(reqValid), .reqKind(reqKind),
    .ctl(ctl), .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .rfshN(rfshN),
    .cycDone(cycDone), .rStep(rStep)
  );

  fbs_dpath #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dataIn(dataIn), .iReg(iReg), .rReg(rReg), .addr(addr), .dataOut(dataOut),
    .dataOe(dataOe), .rdData(rdData), .rNext(rNext)
  );

endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] iReg,
  input logic [DATA_W-1:0] rReg,
  input logic              dataOe,
  input logic              m1N,
  input logic              mreqN,
  input logic              rdN,
  input logic              wrN,
  input logic              rfshN,
  input logic              cycDone,
  input logic              rStep
);

  // R1
  fetch_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(m1N) |=> (!mreqN && !rdN && !m1N));

  // R4
  rfsh_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> (addr == {iReg, rReg} && rdN && m1N));

  // R5
  rstep_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    rStep |-> (cycDone && !rfshN));

  // R7
  no_rd_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> dataOe);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cycDone |=> !cycDone);

endmodule

bind fetch_bus_seq fbs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .iReg(iReg), .rReg(rReg), .dataOe(dataOe),
  .m1N(m1N), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .rfshN(rfshN),
  .cycDone(cycDone), .rStep(rStep)
);

// File: tb/fetch_bus_seq_test.sv
`timescale 1ns/1ps
module fetch_bus_seq_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic waitN = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [15:0] reqAddr = 16'h0000;
  logic [7:0] reqWdata = 8'h00;
  logic [7:0] iReg = 8'h3C;
  logic [7:0] rReg = 8'h00;
  logic [7:0] dataIn;
  logic [15:0] addr;
  logic [7:0] dataOut, rdData, rNext;
  logic dataOe, m1N, mreqN, rdN, wrN, rfshN, cycDone, rStep;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h31;
  endfunction

  assign dataIn = rdN ? 8'hEE : memf(addr);

  fetch_bus_seq uut (
    .clk(clk), .rstN(rstN), .waitN(waitN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .iReg(iReg), .rReg(rReg), .dataIn(dataIn),
    .addr(addr), .dataOut(dataOut), .dataOe(dataOe), .m1N(m1N), .mreqN(mreqN),
    .rdN(rdN), .wrN(wrN), .rfshN(rfshN), .rdData(rdData), .cycDone(cycDone),
    .rStep(rStep), .rNext(rNext)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] a;
    logic [7:0]  wd;
    int          w;
    bit          b2b;
  } item_t;
  item_t sbq[$];

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle observations
  int nClk = 0, m1Cnt = 0, rdCnt = 0, mreqCnt = 0, mreqFalls = 0, wrCnt = 0;
  int oeCnt = 0, rfshCnt = 0, badRfsh = 0, badAddr = 0, badOe = 0;
  logic prevMreq = 1'b1;
  logic [15:0] wrA = '0;
  logic [7:0] wrD = '0;

  task automatic judge();
    item_t it;
    int w;
    logic [7:0] expR;
    if (sbq.size() == 0) begin
      chk(0, "R9 done with no request", 1, 0);
      return;
    end
    it = sbq.pop_front();
    w = it.w;
    if (it.kind == 2'd0) begin
      if (it.b2b) chk(nClk == 8 + 2*w, "R9 fetch length", nClk, 8 + 2*w);
      chk(badAddr == 0, "R1 fetch address", badAddr, 0);
      chk(m1Cnt == 4 + 2*w, "R1 m1 low clocks", m1Cnt, 4 + 2*w);
      chk(rdCnt == 3 + 2*w, "R2 fetch rd low clocks", rdCnt, 3 + 2*w);
      chk(rdData == memf(it.a), "R3 opcode", rdData, memf(it.a));
      chk(mreqFalls == 2, "R4 mreq pulses", mreqFalls, 2);
      chk(mreqCnt == 5 + 2*w, "R4 mreq low clocks", mreqCnt, 5 + 2*w);
      chk(rfshCnt == 4 && badRfsh == 0, "R4 refresh", rfshCnt, 4);
      expR = {rReg[7], rReg[6:0] + 7'd1};
      chk(rStep == 1'b1, "R5 step", rStep, 1);
      chk(rNext == expR, "R5 next count", rNext, expR);
      rReg = expR;
    end else if (it.kind == 2'd1) begin
      if (it.b2b) chk(nClk == 6 + 2*w, "R9 read length", nClk, 6 + 2*w);
      chk(badAddr == 0, "R6 read address", badAddr, 0);
      chk(rdCnt == 4 + 2*w && mreqCnt == 4 + 2*w, "R6 R2 read strobes", rdCnt, 4 + 2*w);
      chk(m1Cnt == 0 && rfshCnt == 0, "R6 no m1 or refresh", m1Cnt + rfshCnt, 0);
      chk(rdData == memf(it.a), "R6 read data", rdData, memf(it.a));
      chk(rStep == 1'b0, "R5 no step on read", rStep, 0);
    end else begin
      if (it.b2b) chk(nClk == 6 + 2*w, "R9 write length", nClk, 6 + 2*w);
      chk(wrCnt == 2 + 2*w, "R7 R2 wr low clocks", wrCnt, 2 + 2*w);
      chk(oeCnt == 6 + 2*w && badOe == 0, "R7 data drive", oeCnt, 6 + 2*w);
      chk(mreqCnt == 4 + 2*w && rdCnt == 0, "R7 mreq without rd", mreqCnt, 4 + 2*w);
      chk(wrD == it.wd, "R7 write data", wrD, it.wd);
      chk(wrA == it.a, "R7 write address", wrA, it.a);
      chk(rStep == 1'b0, "R5 no step on write", rStep, 0);
    end
    nClk = 0; m1Cnt = 0; rdCnt = 0; mreqCnt = 0; mreqFalls = 0; wrCnt = 0;
    oeCnt = 0; rfshCnt = 0; badRfsh = 0; badAddr = 0; badOe = 0;
  endtask

  // monitor and memory model
  always @(negedge clk) begin
    int w;
    if (rstN) begin
      w = (sbq.size() > 0) ? sbq[0].w : 0;
      nClk++;
      if (!m1N) m1Cnt++;
      if (!rdN) rdCnt++;
      if (!mreqN) begin
        mreqCnt++;
        if (prevMreq) mreqFalls++;
      end
      prevMreq = mreqN;
      if (!wrN) begin
        wrCnt++;
        wrA = addr;
        wrD = dataOut;
        if (!dataOe) badOe++;
      end
      if (dataOe) oeCnt++;
      if (!rfshN) begin
        rfshCnt++;
        if (addr != {iReg, rReg}) badRfsh++;
      end
      if ((!rdN || !wrN) && rfshN && sbq.size() > 0 && addr != sbq[0].a) badAddr++;
      waitN = !(w > 0 && mreqCnt >= 1 && mreqCnt <= 2*w);
      if (rStep && !cycDone) chk(0, "R5 step outside done", 1, 0);
      if (cycDone) judge();
    end else begin
      prevMreq = 1'b1;
    end
  end

  task automatic waitDone();
    do begin
      @(negedge clk); #1;
    end while (!cycDone);
  endtask

  task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] wd,
                       input int w, input bit b2b);
    item_t it;
    it.kind = k; it.a = a; it.wd = wd; it.w = w; it.b2b = b2b;
    sbq.push_back(it);
    reqKind = k; reqAddr = a; reqWdata = wd; reqValid = 1'b1;
    waitDone();
  endtask

  task automatic goIdle();
    reqValid = 1'b0;
    repeat (4) begin
      @(negedge clk); #1;
      chk(m1N && mreqN && rdN && wrN && rfshN && !dataOe && !cycDone, "R10 idle bus",
          {m1N, mreqN, rdN, wrN, rfshN}, 5'h1F);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #500000;
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    item_t first;
    repeat (4) begin
      @(negedge clk); #1;
      chk(m1N && mreqN && rdN && wrN && rfshN, "R8 strobes in reset",
          {m1N, mreqN, rdN, wrN, rfshN}, 5'h1F);
      chk(!dataOe && !cycDone, "R8 outputs quiet in reset", {dataOe, cycDone}, 0);
    end
    // request waiting across reset release
    first.kind = 2'd0; first.a = 16'h0000; first.wd = 8'h00; first.w = 0; first.b2b = 0;
    sbq.push_back(first);
    reqKind = 2'd0; reqAddr = 16'h0000; reqValid = 1'b1;
    @(negedge clk); #1 rstN = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); #1;
      chk(m1N && mreqN, "R8 dummy states", {m1N, mreqN}, 2'b11);
    end
    @(negedge clk); #1;
    chk(!m1N && addr == 16'h0000, "R8 first fetch start", {m1N, addr}, 0);
    waitDone();

    issue(2'd0, 16'h1234, 8'h00, 0, 1);
    issue(2'd0, 16'h2001, 8'h00, 2, 1);
    issue(2'd1, 16'h8001, 8'h00, 0, 1);
    issue(2'd1, 16'h4321, 8'h00, 3, 1);
    issue(2'd2, 16'h9ABC, 8'hA5, 0, 1);
    issue(2'd2, 16'h0F0F, 8'h3C, 1, 1);
    issue(2'd0, 16'h5566, 8'h00, 1, 1);
    goIdle();

    rReg = 8'h7F;
    issue(2'd0, 16'h7000, 8'h00, 0, 0);
    rReg = 8'hFF;
    iReg = 8'h81;
    issue(2'd0, 16'hC0DE, 8'h00, 0, 1);
    issue(2'd1, 16'h00FF, 8'h00, 1, 1);
    issue(2'd2, 16'hFFFE, 8'h5A, 2, 1);
    goIdle();

    chk(sbq.size() == 0, "R9 all cycles completed", sbq.size(), 0);
    summary();
  end

endmodule